// File: doc/BRIEF.md
# D-PHY Power-Up Sequencer

This controller brings a serial display PHY out of reset and puts it back into shutdown. A one-cycle `start_i` pulse runs the bring-up. First the three PHY control lines (active-low reset, active-low shutdown, clock enable) are driven low one after another. Then the test-clear line gets a low-high-low pulse. After that the sequencer asks an external agent to load the PLL and timing settings and waits for it to acknowledge.

Once the settings are acknowledged, the PHY is released in a fixed order: shutdown first, then reset, then the minimum stop time is written, then the clock enable goes high, and last the lane count is written. The sequencer then samples the PLL lock input at a fixed interval, up to a bounded number of samples. It ends with a one-cycle `done_o` if lock is seen and a one-cycle `err_o` if it is not.

A `stop_i` pulse runs the power-down. Reset goes low, then shutdown goes low, then reset is released again. Every control step is held for a parameterised number of clocks before the next step starts.

Top module: `dphy_pwrup_seq`

## Requirements
- R1: After reset every output is 0.
- R2: An accepted start drives `phy_rst_n_o` low, then `phy_shut_n_o` low, then `phy_clk_en_o` low. It then drives `test_clr_o` low, high and low again. Each step takes effect HOLD_CYCLES clocks after the previous one.
- R3: HOLD_CYCLES clocks after the final test-clear step, `cfg_req_o` rises. It stays high, with all four PHY control lines low, until `cfg_done_i` is sampled high. On that same edge `cfg_req_o` falls.
- R4: On the edge that samples `cfg_done_i` high, `phy_shut_n_o` rises. HOLD_CYCLES clocks apart, the following changes then take effect in this order: `phy_rst_n_o` rises, `stop_time_o` takes STOP_TIME (default 0x1C), `phy_clk_en_o` rises, and `lane_cfg_o` is written.
- R5: The value written to `lane_cfg_o` is `lanes_i` minus one for `lanes_i` in 1..MAX_LANES. It is 0 when `lanes_i` is 0 and MAX_LANES-1 when `lanes_i` is above MAX_LANES.
- R6: HOLD_CYCLES clocks after the lane write, `pll_lock_i` is sampled. It is sampled again every POLL_IVL clocks. The first sample that is high ends the sequence with `done_o`.
- R7: If POLL_LIMIT samples in a row are all low, the sequence ends with `err_o`, and the PHY control lines keep their values.
- R8: An accepted stop drives `phy_rst_n_o` low, then `phy_shut_n_o` low, then `phy_rst_n_o` high, each step HOLD_CYCLES clocks after the previous one. It ends with `done_o` HOLD_CYCLES clocks after the last step. `phy_clk_en_o`, `stop_time_o` and `lane_cfg_o` are left unchanged.
- R9: `busy_o` rises on the edge that accepts a start or stop. It stays high until the sequence ends. A start or stop that arrives while busy is ignored.
- R10: If start and stop arrive in the same idle cycle, the start sequence runs.
- R11: `done_o` and `err_o` are one-cycle pulses and are never high together. Each occurs on the edge where `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Bring-up request pulse |
| stop_i | input | 1 | Power-down request pulse |
| cfg_done_i | input | 1 | PLL/timing setup finished |
| pll_lock_i | input | 1 | PHY PLL lock status |
| lanes_i | input | $clog2(MAX_LANES+1) | Number of active data lanes |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| phy_shut_n_o | output | 1 | PHY shutdown, active low |
| phy_clk_en_o | output | 1 | PHY clock enable |
| test_clr_o | output | 1 | PHY test-interface clear |
| cfg_req_o | output | 1 | Request to load PLL/timing setup |
| stop_time_o | output | STOP_W | Minimum stop-state time |
| lane_cfg_o | output | $clog2(MAX_LANES) | Lane count minus one |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Lock poll timed out |

## Verification
The assertions check the following on every cycle:
- the control lines stay low while setup is requested;
- test-clear only toggles while reset and clock enable are held low;
- shutdown is released while reset is still asserted, and the clock enable only rises after both are released;
- an idle request is always accepted, and no busy state starts spontaneously;
- the end-of-sequence flags behave as exclusive pulses at the fall of busy.

Some behaviours only the bench's scenarios can show:
- the exact spacing of each step;
- which sample of the lock input ends the poll;
- that start wins over a simultaneous stop;
- that requests arriving mid-sequence leave the timeline untouched;
- the lane-count clamping at both ends.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_RST_LO,
        ST_SHUT_LO,
        ST_CLK_LO,
        ST_TCLR_LO,
        ST_TCLR_HI,
        ST_TCLR_END,
        ST_CFG,
        ST_SHUT_HI,
        ST_RST_HI,
        ST_STOPT,
        ST_CLK_HI,
        ST_LANES,
        ST_POLL,
        ST_DN_RST_LO,
        ST_DN_SHUT_LO,
        ST_DN_RST_HI
    } seq_state_e;

    // Successor of every timed step; untimed states map to idle.
    function automatic seq_state_e step_next(input seq_state_e s);
        case (s)
            ST_RST_LO:     return ST_SHUT_LO;
            ST_SHUT_LO:    return ST_CLK_LO;
            ST_CLK_LO:     return ST_TCLR_LO;
            ST_TCLR_LO:    return ST_TCLR_HI;
            ST_TCLR_HI:    return ST_TCLR_END;
            ST_TCLR_END:   return ST_CFG;
            ST_SHUT_HI:    return ST_RST_HI;
            ST_RST_HI:     return ST_STOPT;
            ST_STOPT:      return ST_CLK_HI;
            ST_CLK_HI:     return ST_LANES;
            ST_LANES:      return ST_POLL;
            ST_DN_RST_LO:  return ST_DN_SHUT_LO;
            ST_DN_SHUT_LO: return ST_DN_RST_HI;
            default:       return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dphy_hold_timer.sv
module dphy_hold_timer #(
    parameter int HOLD_CYCLES = 4,
    localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expire_o
);

    logic [HW-1:0] cnt_d, cnt_q;

    assign expire_o = (cnt_q == HW'(HOLD_CYCLES - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (!expire_o)
            cnt_d = cnt_q + HW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dphy_lock_poller.sv
module dphy_lock_poller #(
    parameter int POLL_IVL   = 375,
    parameter int POLL_LIMIT = 50000,
    localparam int IW = $clog2(POLL_IVL + 1),
    localparam int AW = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic run_i,
    output logic sample_o,
    output logic last_o
);

    logic [IW-1:0] ivl_d, ivl_q;
    logic [AW-1:0] att_d, att_q;

    assign sample_o = run_i && (ivl_q == '0);
    assign last_o   = (att_q == AW'(POLL_LIMIT - 1));

    always_comb begin
        ivl_d = ivl_q;
        att_d = att_q;
        if (arm_i) begin
            ivl_d = '0;
            att_d = '0;
        end else if (run_i) begin
            if (ivl_q == '0) begin
                ivl_d = IW'(POLL_IVL - 1);
                if (!last_o) att_d = att_q + AW'(1);
            end else begin
                ivl_d = ivl_q - IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q <= '0;
            att_q <= '0;
        end else begin
            ivl_q <= ivl_d;
            att_q <= att_d;
        end
    end

endmodule

// File: rtl/dphy_pwrup_seq.sv
module dphy_pwrup_seq
    import dphy_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int POLL_IVL    = 375,
    parameter int POLL_LIMIT  = 50000,
    parameter int MAX_LANES   = 4,
    parameter int STOP_W      = 8,
    parameter logic [STOP_W-1:0] STOP_TIME = 8'h1C,
    localparam int CNT_W  = $clog2(MAX_LANES + 1),
    localparam int LCFG_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              cfg_done_i,
    input  logic              pll_lock_i,
    input  logic [CNT_W-1:0]  lanes_i,
    output logic              phy_rst_n_o,
    output logic              phy_shut_n_o,
    output logic              phy_clk_en_o,
    output logic              test_clr_o,
    output logic              cfg_req_o,
    output logic [STOP_W-1:0] stop_time_o,
    output logic [LCFG_W-1:0] lane_cfg_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        seq_state_e        st;
        logic              rst_n;
        logic              shut_n;
        logic              clk_en;
        logic              tclr;
        logic              req;
        logic              busy;
        logic              done;
        logic              err;
        logic [STOP_W-1:0] stop;
        logic [LCFG_W-1:0] lane;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic hold_clr, hold_exp;
    logic poll_arm, poll_run, poll_smp, poll_last;
    logic [CNT_W-1:0]  lane_sel;
    logic [LCFG_W-1:0] lane_val;

    dphy_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (hold_clr),
        .expire_o (hold_exp)
    );

    dphy_lock_poller #(.POLL_IVL(POLL_IVL), .POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (poll_arm),
        .run_i    (poll_run),
        .sample_o (poll_smp),
        .last_o   (poll_last)
    );

    // Lane count minus one, clamped to the supported range.
    always_comb begin
        if (lanes_i == '0)
            lane_sel = '0;
        else if (lanes_i > CNT_W'(MAX_LANES))
            lane_sel = CNT_W'(MAX_LANES - 1);
        else
            lane_sel = lanes_i - CNT_W'(1);
        lane_val = LCFG_W'(lane_sel);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_RST_LO;
                    r_d.busy  = 1'b1;
                    r_d.rst_n = 1'b0;
                end else if (stop_i) begin
                    r_d.st    = ST_DN_RST_LO;
                    r_d.busy  = 1'b1;
                    r_d.rst_n = 1'b0;
                end
            end
            ST_CFG: begin
                if (cfg_done_i) begin
                    r_d.st     = ST_SHUT_HI;
                    r_d.req    = 1'b0;
                    r_d.shut_n = 1'b1;
                end
            end
            ST_POLL: begin
                if (poll_smp && pll_lock_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else if (poll_smp && poll_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end
            end
            default: begin
                if (hold_exp) begin
                    r_d.st = step_next(r_q.st);
                    case (r_d.st)
                        ST_SHUT_LO, ST_DN_SHUT_LO: r_d.shut_n = 1'b0;
                        ST_CLK_LO:                 r_d.clk_en = 1'b0;
                        ST_TCLR_LO, ST_TCLR_END:   r_d.tclr   = 1'b0;
                        ST_TCLR_HI:                r_d.tclr   = 1'b1;
                        ST_CFG:                    r_d.req    = 1'b1;
                        ST_RST_HI, ST_DN_RST_HI:   r_d.rst_n  = 1'b1;
                        ST_STOPT:                  r_d.stop   = STOP_TIME;
                        ST_CLK_HI:                 r_d.clk_en = 1'b1;
                        ST_LANES:                  r_d.lane   = lane_val;
                        ST_IDLE: begin
                            r_d.busy = 1'b0;
                            r_d.done = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    assign hold_clr = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);
    assign poll_arm = (r_d.st == ST_POLL) && (r_q.st != ST_POLL);
    assign poll_run = (r_q.st == ST_POLL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign phy_rst_n_o  = r_q.rst_n;
    assign phy_shut_n_o = r_q.shut_n;
    assign phy_clk_en_o = r_q.clk_en;
    assign test_clr_o   = r_q.tclr;
    assign cfg_req_o    = r_q.req;
    assign stop_time_o  = r_q.stop;
    assign lane_cfg_o   = r_q.lane;
    assign busy_o       = r_q.busy;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;

endmodule

// File: rtl/dphy_pwrup_seq_chk.sv
module dphy_pwrup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic cfg_req_o,
    input logic test_clr_o,
    input logic phy_rst_n_o,
    input logic phy_shut_n_o,
    input logic phy_clk_en_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);

    AST_CFG_CONTROLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o |-> (!phy_rst_n_o && !phy_shut_n_o && !phy_clk_en_o && !test_clr_o)); // R3

    AST_TCLR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        test_clr_o |-> (busy_o && !phy_rst_n_o && !phy_clk_en_o)); // R2

    AST_SHUT_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_shut_n_o) |-> !phy_rst_n_o); // R4

    AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_clk_en_o) |-> (phy_rst_n_o && phy_shut_n_o)); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !stop_i) |=> !busy_o); // R9

    AST_REQ_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (start_i || stop_i)) |=> busy_o); // R9

    AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o != err_o)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> !busy_o); // R11

endmodule

bind dphy_pwrup_seq dphy_pwrup_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .cfg_req_o    (cfg_req_o),
    .test_clr_o   (test_clr_o),
    .phy_rst_n_o  (phy_rst_n_o),
    .phy_shut_n_o (phy_shut_n_o),
    .phy_clk_en_o (phy_clk_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/dphy_pwrup_seq_tb_top.sv
module dphy_pwrup_seq_tb_top;

    localparam int HOLD  = 2;
    localparam int IVL   = 3;
    localparam int LIMIT = 4;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, cfg_done_i = 1'b0, pll_lock_i = 1'b0;
    logic [2:0] lanes_i = 3'd0;
    logic phy_rst_n_o, phy_shut_n_o, phy_clk_en_o, test_clr_o, cfg_req_o;
    logic [7:0] stop_time_o;
    logic [1:0] lane_cfg_o;
    logic busy_o, done_o, err_o;

    int checks = 0, errors = 0, cycles = 0, n_done = 0, n_err = 0;

    always #4 clk = ~clk;

    dphy_pwrup_seq #(.HOLD_CYCLES(HOLD), .POLL_IVL(IVL), .POLL_LIMIT(LIMIT),
                     .MAX_LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .cfg_done_i(cfg_done_i), .pll_lock_i(pll_lock_i), .lanes_i(lanes_i),
        .phy_rst_n_o(phy_rst_n_o), .phy_shut_n_o(phy_shut_n_o),
        .phy_clk_en_o(phy_clk_en_o), .test_clr_o(test_clr_o),
        .cfg_req_o(cfg_req_o), .stop_time_o(stop_time_o),
        .lane_cfg_o(lane_cfg_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    // Behavioural reference: phase numbers follow the requirement steps.
    int m_ph = 0, m_cnt = 0, m_ivl = 0, m_att = 0;
    bit m_rst = 0, m_shut = 0, m_clk = 0, m_tclr = 0, m_req = 0;
    bit m_busy = 0, m_done = 0, m_err = 0;
    int m_stop = 0, m_lane = 0;

    function automatic int lane_of(int n);
        if (n == 0) return 0;
        if (n > LANES) return LANES - 1;
        return n - 1;
    endfunction

    task automatic m_enter(int p);
        m_ph = p;
        m_cnt = 0;
        case (p)
            1, 20: m_rst = 0;
            2, 21: m_shut = 0;
            3: m_clk = 0;
            4, 6: m_tclr = 0;
            5: m_tclr = 1;
            7: m_req = 1;
            8: begin m_req = 0; m_shut = 1; end
            9, 22: m_rst = 1;
            10: m_stop = 8'h1C;
            11: m_clk = 1;
            12: m_lane = lane_of(int'(lanes_i));
            13: begin m_ivl = 0; m_att = 0; end
            default: ;
        endcase
    endtask

    task automatic m_finish(bit ok);
        m_ph = 0;
        m_busy = 0;
        m_done = ok;
        m_err = !ok;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rst = 0; m_shut = 0; m_clk = 0; m_tclr = 0; m_req = 0;
            m_busy = 0; m_done = 0; m_err = 0; m_stop = 0; m_lane = 0;
        end else begin
            m_done = 0;
            m_err = 0;
            if (m_ph == 0) begin
                if (start_i) begin m_busy = 1; m_enter(1); end
                else if (stop_i) begin m_busy = 1; m_enter(20); end
            end else if (m_ph == 7) begin
                if (cfg_done_i) m_enter(8);
            end else if (m_ph == 13) begin
                if (m_ivl == 0) begin
                    if (pll_lock_i) m_finish(1);
                    else begin
                        m_att++;
                        if (m_att == LIMIT) m_finish(0);
                        else m_ivl = IVL - 1;
                    end
                end else m_ivl--;
            end else if (m_cnt == HOLD - 1) begin
                if (m_ph == 22) m_finish(1);
                else m_enter(m_ph + 1);
            end else m_cnt++;
        end
    end

    function automatic string tag_of(int p);
        if (p == 0) return "R11";
        if (p <= 6) return "R2";
        if (p == 7) return "R3";
        if (p <= 11) return "R4";
        if (p == 12) return "R5";
        if (p == 13) return "R6";
        return "R8";
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int act = {phy_rst_n_o, phy_shut_n_o, phy_clk_en_o, test_clr_o,
                                 cfg_req_o, busy_o, done_o, err_o, stop_time_o, lane_cfg_o};
            automatic int exp = {m_rst, m_shut, m_clk, m_tclr, m_req, m_busy, m_done,
                                 m_err, 8'(m_stop), 2'(m_lane)};
            chk(act == exp, tag_of(m_ph), act, exp);
            if (done_o) n_done++;
            if (err_o) n_err++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1; tick(1); start_i = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy_o; i++) tick(1);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 2000 && !cfg_req_o; i++) tick(1);
    endtask

    task automatic ack_cfg(int dly);
        wait_req();
        tick(dly);
        cfg_done_i = 1; tick(1); cfg_done_i = 0;
    endtask

    initial begin
        int d0, e0;
        tick(3);
        chk({phy_rst_n_o, phy_shut_n_o, phy_clk_en_o, test_clr_o, cfg_req_o,
             busy_o, done_o, err_o} == 8'h00 && stop_time_o == 0 && lane_cfg_o == 0,
            "R1", int'(stop_time_o), 0);
        rst_n = 1;
        tick(2);

        // Bring-up, two lanes, lock already present.
        lanes_i = 3'd2; pll_lock_i = 1; d0 = n_done;
        pulse_start();
        chk(busy_o == 1, "R9", int'(busy_o), 1);
        wait_req();
        tick(4);
        chk(cfg_req_o == 1, "R3", int'(cfg_req_o), 1);
        ack_cfg(0);
        wait_idle(); tick(1);
        chk(n_done == d0 + 1, "R6", n_done - d0, 1);
        chk(lane_cfg_o == 2'd1, "R5", int'(lane_cfg_o), 1);
        chk(stop_time_o == 8'h1C, "R4", int'(stop_time_o), 8'h1C);

        // Four lanes, late lock, extra requests while busy.
        lanes_i = 3'd4; pll_lock_i = 0; d0 = n_done;
        pulse_start();
        tick(2); pulse_start(); stop_i = 1; tick(1); stop_i = 0;
        ack_cfg(3);
        tick(16); pll_lock_i = 1;
        wait_idle(); tick(1);
        chk(n_done == d0 + 1, "R9", n_done - d0, 1);
        chk(lane_cfg_o == 2'd3, "R5", int'(lane_cfg_o), 3);

        // Zero lanes, lock never arrives.
        lanes_i = 3'd0; pll_lock_i = 0; e0 = n_err;
        pulse_start();
        ack_cfg(1);
        wait_idle(); tick(1);
        chk(n_err == e0 + 1, "R7", n_err - e0, 1);
        chk({phy_rst_n_o, phy_shut_n_o, phy_clk_en_o} == 3'b111, "R7",
            int'({phy_rst_n_o, phy_shut_n_o, phy_clk_en_o}), 7);
        chk(lane_cfg_o == 2'd0, "R5", int'(lane_cfg_o), 0);

        // Power-down.
        d0 = n_done;
        stop_i = 1; tick(1); stop_i = 0;
        wait_idle(); tick(1);
        chk(n_done == d0 + 1, "R8", n_done - d0, 1);
        chk({phy_rst_n_o, phy_shut_n_o, phy_clk_en_o} == 3'b101, "R8",
            int'({phy_rst_n_o, phy_shut_n_o, phy_clk_en_o}), 5);
        chk(stop_time_o == 8'h1C, "R8", int'(stop_time_o), 8'h1C);

        // Simultaneous start and stop; lane count above range.
        lanes_i = 3'd7; pll_lock_i = 1;
        start_i = 1; stop_i = 1; tick(1); start_i = 0; stop_i = 0;
        wait_req();
        chk(cfg_req_o == 1, "R10", int'(cfg_req_o), 1);
        ack_cfg(2);
        wait_idle(); tick(1);
        chk(lane_cfg_o == 2'd3, "R5", int'(lane_cfg_o), 3);
        chk(n_err == e0 + 1, "R11", n_err - e0, 1);

        tick(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (;;) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule